// File: doc/BRIEF.md
# Smart Overcurrent Shutdown Controller

This block sits between a three-phase gate driver and a single shared shutdown pin. It takes an overcurrent comparator flag, already synchronized to the core clock, and the sampled logic level of the open-drain shutdown pin. From these it produces two controls. The first is a kill signal that blanks every high-side and low-side gate command at once. The second is an enable for the on-chip pulldown transistor on the shutdown pin.

When the comparator trips, the gates are blanked in the same cycle, without waiting for the pin to discharge. The block then pulls the shutdown pin low and keeps pulling until the pin itself reads low. At that point the pulldown is released. The external pull-up recharges the pin, and normal gate driving resumes once the pin reads high again. The effective disable time is therefore at least the discharge and recharge time of the external network, plus the time spent holding the pin low.

One comparator and one pin serve all legs. The gate requests pass through a per-leg masking stage that the kill signal controls. A single-cycle event pulse and a saturating event counter report each entry into the pulldown phase.

Top module: `smart_shutdown_ctrl`

## Requirements
- R1: In any cycle where `cmp_trip` is 1, `gate_kill` is 1 in that same cycle, with no clock edge in between.
- R2: While `gate_kill` is 1, every bit of `gate_hi_drv` and `gate_lo_drv` is 0. While `gate_kill` is 0, `gate_hi_drv` equals `gate_hi_req` and `gate_lo_drv` equals `gate_lo_req`.
- R3: If `cmp_trip` is 1 and `sd_pin_lvl` is 1 at a rising clock edge, `sd_pull_en` is 1 after that edge.
- R4: Once asserted, `sd_pull_en` stays 1 at every edge where `sd_pin_lvl` reads 1, even after `cmp_trip` has returned to 0.
- R5: If `sd_pull_en` is 1 and `sd_pin_lvl` reads 0 at an edge, `sd_pull_en` is 0 after that edge.
- R6: After the pulldown is released, `gate_kill` stays 1 until `sd_pin_lvl` has been sampled 1 at an edge with `cmp_trip` at 0. `gate_kill` then falls after that edge.
- R7: A `cmp_trip` of 1 at an edge while waiting for the pin to recover takes priority over the pin reading 1. `sd_pull_en` returns to 1 after that edge.
- R8: With no fault in progress, `sd_pin_lvl` at 0 (the pin is pulled low from outside) makes `gate_kill` 1 in the same cycle and leaves `sd_pull_en` at 0.
- R9: `fault_pulse` is 1 for exactly the cycle in which `sd_pull_en` rises from 0 to 1.
- R10: `fault_count` increases by one on each rise of `sd_pull_en`, changes at no other time, and holds at 2^CNT_W-1 once it reaches that value.
- R11: While `rst_n` is 0, `sd_pull_en`, `fault_pulse` and `fault_count` are 0, taking effect at once even in the middle of a fault. `gate_kill` then depends only on `cmp_trip` and `sd_pin_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmp_trip | input | 1 | Synchronized overcurrent comparator flag, 1 = overcurrent |
| sd_pin_lvl | input | 1 | Sampled level of the shared shutdown pin, 1 = above the logic-high threshold |
| gate_hi_req | input | LEGS | High-side gate requests, one bit per leg |
| gate_lo_req | input | LEGS | Low-side gate requests, one bit per leg |
| sd_pull_en | output | 1 | Enable for the open-drain pulldown on the shutdown pin |
| gate_kill | output | 1 | Fast blanking signal to the gate logic, 1 = all gates off |
| gate_hi_drv | output | LEGS | Masked high-side gate commands |
| gate_lo_drv | output | LEGS | Masked low-side gate commands |
| fault_pulse | output | 1 | One-cycle pulse on each entry into the pulldown phase |
| fault_count | output | CNT_W | Saturating count of pulldown entries |

## Verification
The properties assume that `cmp_trip` and `sd_pin_lvl` are already synchronous to `clk` and stable around each rising edge. They also assume the pin reads low only because of the block's own pulldown or an outside agent, never as a glitch within a cycle. The stimulus changes every input on the falling edge and checks the outputs just after. Combinational results such as the kill path are seen before the next rising edge, and registered results reflect all edges up to that point. Fault sequences always present the pin as falling after the pulldown is enabled and rising only once the pulldown is off. This matches what an external RC network would do.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

  // Controller phases; the pulldown is driven only in SSD_PULL.
  typedef enum logic [1:0] {
    SSD_IDLE    = 2'd0,
    SSD_PULL    = 2'd1,
    SSD_RECOVER = 2'd2
  } ssd_state_e;

endpackage

// File: rtl/ssd_rst_sync.sv
module ssd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ssd_fsm.sv
module ssd_fsm
  import ssd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip,
  input  logic       pin_hi,
  output ssd_state_e state_o,
  output logic       pull_en,
  output logic       entry_now,
  output logic       entry_pulse
);

  ssd_state_e state_q, state_d;
  logic       pulse_q, pulse_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SSD_IDLE:    if (trip) state_d = SSD_PULL;
      SSD_PULL:    if (!pin_hi) state_d = SSD_RECOVER;
      SSD_RECOVER: begin
        if (trip)        state_d = SSD_PULL;
        else if (pin_hi) state_d = SSD_IDLE;
      end
      default:     state_d = SSD_IDLE;
    endcase
  end

  assign entry_now = (state_d == SSD_PULL) && (state_q != SSD_PULL);
  assign pulse_d   = entry_now;

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SSD_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign state_o     = state_q;
  assign pull_en     = (state_q == SSD_PULL);
  assign entry_pulse = pulse_q;

endmodule

// File: rtl/ssd_fault_count.sv
module ssd_fault_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = inc && (cnt_q != CNT_MAX);
  assign cnt_d  = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/ssd_gate_mask.sv
module ssd_gate_mask #(
  parameter int LEGS = 3
) (
  input  logic            kill,
  input  logic [LEGS-1:0] hi_req,
  input  logic [LEGS-1:0] lo_req,
  output logic [LEGS-1:0] hi_drv,
  output logic [LEGS-1:0] lo_drv
);

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    assign hi_drv[g] = hi_req[g] & ~kill;
    assign lo_drv[g] = lo_req[g] & ~kill;
  end

endmodule

// File: rtl/smart_shutdown_ctrl.sv
module smart_shutdown_ctrl
  import ssd_pkg::*;
#(
  parameter int LEGS       = 3,
  parameter int CNT_W      = 4,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_trip,
  input  logic             sd_pin_lvl,
  input  logic [LEGS-1:0]  gate_hi_req,
  input  logic [LEGS-1:0]  gate_lo_req,
  output logic             sd_pull_en,
  output logic             gate_kill,
  output logic [LEGS-1:0]  gate_hi_drv,
  output logic [LEGS-1:0]  gate_lo_drv,
  output logic             fault_pulse,
  output logic [CNT_W-1:0] fault_count
);

  logic       rst_core_n;
  ssd_state_e fsm_state;
  logic       entry_now;

  ssd_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ssd_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .trip        (cmp_trip),
    .pin_hi      (sd_pin_lvl),
    .state_o     (fsm_state),
    .pull_en     (sd_pull_en),
    .entry_now   (entry_now),
    .entry_pulse (fault_pulse)
  );

  ssd_fault_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_core_n),
    .inc   (entry_now),
    .count (fault_count)
  );

  // Preferential path: the comparator blanks the gates without a register.
  assign gate_kill = cmp_trip | ~sd_pin_lvl | (fsm_state != SSD_IDLE);

  ssd_gate_mask #(.LEGS(LEGS)) u_mask (
    .kill   (gate_kill),
    .hi_req (gate_hi_req),
    .lo_req (gate_lo_req),
    .hi_drv (gate_hi_drv),
    .lo_drv (gate_lo_drv)
  );

endmodule

// File: rtl/ssd_checker.sv
module ssd_checker #(
  parameter int LEGS  = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_trip,
  input logic             sd_pin_lvl,
  input logic             sd_pull_en,
  input logic             gate_kill,
  input logic [LEGS-1:0]  gate_hi_drv,
  input logic [LEGS-1:0]  gate_lo_drv,
  input logic             fault_pulse,
  input logic [CNT_W-1:0] fault_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r1_trip_kills: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_trip |-> gate_kill);

  a_r2_gates_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    gate_kill |-> (gate_hi_drv == '0 && gate_lo_drv == '0));

  a_r3_pull_after_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_trip && sd_pin_lvl) |=> sd_pull_en);

  a_r4_pull_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_pull_en && sd_pin_lvl) |=> sd_pull_en);

  a_r5_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_pull_en && !sd_pin_lvl) |=> !sd_pull_en);

  a_r8_pin_low_kills: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_pin_lvl |-> gate_kill);

  a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> $rose(sd_pull_en));

  a_r10_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_pulse |-> $stable(fault_count));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pulse && $past(fault_count) != CNT_MAX)
      |-> fault_count == $past(fault_count) + CNT_W'(1));

endmodule

bind smart_shutdown_ctrl ssd_checker #(.LEGS(LEGS), .CNT_W(CNT_W)) u_ssd_checker (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .cmp_trip    (cmp_trip),
  .sd_pin_lvl  (sd_pin_lvl),
  .sd_pull_en  (sd_pull_en),
  .gate_kill   (gate_kill),
  .gate_hi_drv (gate_hi_drv),
  .gate_lo_drv (gate_lo_drv),
  .fault_pulse (fault_pulse),
  .fault_count (fault_count)
);

// File: tb/smart_shutdown_ctrl_bench.sv
module smart_shutdown_ctrl_bench;

  localparam int LEGS  = 3;
  localparam int CNT_W = 4;
  localparam int NVEC  = 16;

  logic             clk;
  logic             rst_n;
  logic             cmp_trip;
  logic             sd_pin_lvl;
  logic [LEGS-1:0]  gate_hi_req;
  logic [LEGS-1:0]  gate_lo_req;
  logic             sd_pull_en;
  logic             gate_kill;
  logic [LEGS-1:0]  gate_hi_drv;
  logic [LEGS-1:0]  gate_lo_drv;
  logic             fault_pulse;
  logic [CNT_W-1:0] fault_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  smart_shutdown_ctrl #(.LEGS(LEGS), .CNT_W(CNT_W)) u_smart_shutdown_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_trip    (cmp_trip),
    .sd_pin_lvl  (sd_pin_lvl),
    .gate_hi_req (gate_hi_req),
    .gate_lo_req (gate_lo_req),
    .sd_pull_en  (sd_pull_en),
    .gate_kill   (gate_kill),
    .gate_hi_drv (gate_hi_drv),
    .gate_lo_drv (gate_lo_drv),
    .fault_pulse (fault_pulse),
    .fault_count (fault_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Row: {cmp_trip, sd_pin_lvl, exp_pull, exp_kill, exp_pulse}
  // Inputs applied after a falling edge; outputs reflect edges so far.
  localparam logic [4:0] VEC [NVEC] = '{
    5'b01_000,  // idle, normal driving
    5'b11_010,  // trip: kill at once (R1)
    5'b01_111,  // pulldown on, event pulse (R3, R9)
    5'b01_110,  // pin still high, pulldown held (R4)
    5'b00_110,  // pin low seen
    5'b00_010,  // pulldown released (R5), kill held (R6)
    5'b01_010,  // pin back high, still killed (R6)
    5'b01_000,  // normal again (R6)
    5'b00_010,  // outside pulldown: kill, no pull (R8)
    5'b01_000,
    5'b11_010,  // second trip
    5'b10_111,  // pulldown, pin low with trip still high
    5'b10_010,  // recovering, trip again (R7)
    5'b00_111,  // pulldown re-entered, event pulse (R7, R9)
    5'b01_010,  // recovering
    5'b01_000   // idle
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_fault();
    @(negedge clk); cmp_trip = 1'b1; sd_pin_lvl = 1'b1;
    @(negedge clk); cmp_trip = 1'b0; sd_pin_lvl = 1'b0;
    @(negedge clk); sd_pin_lvl = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    cmp_trip    = 1'b0;
    sd_pin_lvl  = 1'b1;
    gate_hi_req = 3'b101;
    gate_lo_req = 3'b010;
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    check("R11 pull in reset", 32'(sd_pull_en), 32'd0);
    check("R11 pulse in reset", 32'(fault_pulse), 32'd0);
    check("R11 count in reset", 32'(fault_count), 32'd0);
    check("R11 kill in reset", 32'(gate_kill), 32'd0);
    cmp_trip = 1'b1;
    #1;
    check("R11 kill follows trip in reset", 32'(gate_kill), 32'd1);
    cmp_trip = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      cmp_trip   = VEC[i][4];
      sd_pin_lvl = VEC[i][3];
      #1;
      check($sformatf("R3/R4/R5/R7 pull row %0d", i), 32'(sd_pull_en), 32'(VEC[i][2]));
      check($sformatf("R1/R6/R8 kill row %0d", i), 32'(gate_kill), 32'(VEC[i][1]));
      check($sformatf("R9 pulse row %0d", i), 32'(fault_pulse), 32'(VEC[i][0]));
      check($sformatf("R2 hi drv row %0d", i), 32'(gate_hi_drv),
            VEC[i][1] ? 32'd0 : 32'(gate_hi_req));
      check($sformatf("R2 lo drv row %0d", i), 32'(gate_lo_drv),
            VEC[i][1] ? 32'd0 : 32'(gate_lo_req));
    end
    @(negedge clk); #1;
    check("R10 count after three entries", 32'(fault_count), 32'd3);

    // R2 with a different request pattern while idle
    gate_hi_req = 3'b011;
    gate_lo_req = 3'b100;
    #1;
    check("R2 hi pass-through", 32'(gate_hi_drv), 32'd3);
    check("R2 lo pass-through", 32'(gate_lo_drv), 32'd4);

    // R10 saturation
    for (int k = 0; k < 12; k++) run_fault();
    #1;
    check("R10 count reaches max", 32'(fault_count), 32'd15);
    for (int k = 0; k < 2; k++) run_fault();
    #1;
    check("R10 count saturated", 32'(fault_count), 32'd15);

    // R11 asynchronous reset in the middle of a fault
    @(negedge clk); cmp_trip = 1'b1;
    @(negedge clk); cmp_trip = 1'b0;
    #1;
    check("R4 pull held before reset", 32'(sd_pull_en), 32'd1);
    rst_n = 1'b0;
    #1;
    check("R11 pull cleared by reset", 32'(sd_pull_en), 32'd0);
    check("R11 count cleared by reset", 32'(fault_count), 32'd0);
    check("R11 kill released by reset", 32'(gate_kill), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R11 idle after reset", 32'(sd_pull_en), 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule